// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a serial transmit channel from a circular table of buffer descriptors kept in internal memory. Once enabled it starts at the first table entry and keeps re-reading that entry's status word until software marks it ready. It then reads the entry's length and 24-bit buffer pointer and fetches the buffer one 16-bit word at a time, high byte first, into a byte-wide transmit FIFO. When the buffer has been drained it hands the entry back to software by rewriting its status word, then moves to the next entry. It never looks past the current entry and never skips one.

Each descriptor is four 16-bit words at byte offsets 0 (status), 2 (byte count), 4 (pointer bits 23..16 in the low byte) and 6 (pointer bits 15..0). Table entry `i` sits at byte address `TABLE_BASE + 8*i` in internal memory. A status bit selects where each buffer lives. An internal buffer is addressed by the low 11 pointer bits only, and its read data returns on the next clock with no handshake. An external buffer uses the full 24-bit pointer, carries a 3-bit function code, and waits for an acknowledge. Frames may span several descriptors. If the entry after an unfinished frame is not ready when the walker reaches it, the walker reports an underrun.

Top module: `txbd_ring_engine`

## Requirements
- R1: Descriptor words are read from internal memory at `TABLE_BASE + 8*idx` plus offsets 0, 2, 4 and 6. The buffer pointer is formed from bits 7..0 of the offset-4 word (as bits 23..16) and the whole offset-6 word. Bits 15..8 of the offset-4 word are ignored.
- R2: After reset the walker is idle and its table index is 0. While `tx_en` is low in the idle state, it issues no memory request. When polling finds a non-ready entry with `tx_en` low, the walker returns to idle and the index restarts at 0. Status bit 15 is the ready flag, and an entry is polled repeatedly until this flag is 1.
- R3: Entries are served strictly in table order. A ready entry placed after a non-ready current entry is not touched: no FIFO write occurs and no completion is reported until the current entry becomes ready.
- R4: When a served entry has status bit 13 (wrap) set, or is entry `NUM_BD-1`, the next entry used is entry 0. Otherwise the next entry is `idx+1`.
- R5: A buffer of byte count N pushes exactly N bytes. Each fetched word gives its bits 15..8 first and then bits 7..0. For odd N, only the high byte of the final word is pushed. For N = 0, nothing is pushed. Successive words come from pointer, pointer+2, and so on.
- R6: Status bit 12 = 1 selects external space. Such a read drives the full 24-bit pointer on `mem_addr`, with `mem_ext` high and `mem_fc` equal to `tfc`, and holds request and address stable until `mem_ack`. Status bit 12 = 0 selects internal space. Such a read uses only pointer bits 10..0 and takes the data on the following cycle.
- R7: No byte is written to the FIFO while `fifo_full` is high. The walker holds its position until space returns.
- R8: After a buffer is drained, the walker writes the entry's status word back with bit 15 and bit 1 cleared and all other bits kept. `bd_done` is high for exactly that one cycle.
- R9: Status bit 11 = 1 marks the last buffer of a frame. If the entry after a served non-last entry is found not ready, the walker does three things: it writes that entry's status back with bit 1 (underrun) set, pulses `tx_underrun` once, and drops the frame. It then keeps polling the same entry.
- R10: `tfc` equal to 3'b111 raises `cfg_err`. While it is raised, no new external access is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Channel transmit enable |
| tfc | input | 3 | Function code used for external buffer reads |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write (status write-back) |
| mem_ext | output | 1 | Access targets external space |
| mem_fc | output | 3 | Function code of the current access (0 for internal) |
| mem_addr | output | 24 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ack | input | 1 | External access acknowledge |
| fifo_wr | output | 1 | FIFO byte write strobe |
| fifo_data | output | 8 | FIFO byte |
| fifo_full | input | 1 | FIFO cannot accept a byte |
| bd_done | output | 1 | One-cycle pulse as a buffer is handed back |
| tx_underrun | output | 1 | One-cycle pulse when a frame runs out of ready buffers |
| cfg_err | output | 1 | Illegal function code configured |
| bd_idx | output | 3 | Current table entry index |

## Verification
The embedded properties check four things on every cycle: an external read stays requested with a steady address until it is acknowledged, write-backs never leave the ready flag set, completion pulses last a single cycle, and a full FIFO freezes the walker's position. They also check that an underrun pulse coincides with a write that carries the underrun flag, and that no external read begins under an illegal function code. Other properties need whole scenarios and are shown only by the bench's runs: the exact byte stream for odd, even and empty buffers in both spaces, the order in which entries are served, the return to entry 0 on the wrap bit, the refusal to skip a non-ready entry, and the placement of the underrun flag in the right descriptor.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

  localparam int PTR_W  = 24;
  localparam int WORD_W = 16;

  // status word bit positions
  localparam int ST_READY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_EXT   = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_UNDR  = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_RQ, S_POLL_WT, S_LEN_RQ, S_LEN_WT,
    S_PHI_RQ, S_PHI_WT, S_PLO_RQ, S_PLO_WT, S_DAT_RQ,
    S_DAT_WT, S_PUSH_HI, S_PUSH_LO, S_WB, S_UR_WR
  } eng_state_t;

  // byte address of word 'word' of descriptor 'idx'
  function automatic logic [PTR_W-1:0] desc_addr(input logic [PTR_W-1:0] base,
                                                 input logic [PTR_W-1:0] idx,
                                                 input logic [1:0]       word);
    return base + (idx << 3) + {{(PTR_W-3){1'b0}}, word, 1'b0};
  endfunction

  // status word handed back to software
  function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] st,
                                                input logic              ur);
    logic [WORD_W-1:0] w;
    w           = st;
    w[ST_READY] = 1'b0;
    w[ST_UNDR]  = ur;
    return w;
  endfunction

endpackage

// File: rtl/txbd_addr_map.sv
module txbd_addr_map #(
  parameter int PTR_W = 24,
  parameter int INT_W = 11
) (
  input  logic             ext,
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] addr
);
  generate
    if (INT_W >= PTR_W) begin : g_flat
      assign addr = ptr;
    end else begin : g_split
      assign addr = ext ? ptr : {{(PTR_W-INT_W){1'b0}}, ptr[INT_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/txbd_ring_ptr.sv
module txbd_ring_ptr #(
  parameter int NUM_BD = 8,
  parameter int IDXW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic            wrap,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_BD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (adv)    idx <= (wrap || idx == LAST_IDX) ? '0 : idx + 1'b1;
  end

  // R4
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !clr) |=> (idx == '0));

  // R4
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !clr && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txbd_pkg::*;
#(
  parameter int NUM_BD     = 8,
  parameter int INT_W      = 11,
  parameter int TABLE_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [2:0]        tfc,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_ext,
  output logic [2:0]        mem_fc,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  input  logic              fifo_full,
  output logic              bd_done,
  output logic              tx_underrun,
  output logic              cfg_err,
  output logic [((NUM_BD > 1) ? $clog2(NUM_BD) : 1)-1:0] bd_idx
);
  localparam int IDXW = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
  localparam logic [PTR_W-1:0] BASE_A = PTR_W'(TABLE_BASE);
  localparam logic [2:0] FC_BAD = 3'b111;

  eng_state_t        st_q, st_d;
  logic [WORD_W-1:0] stat_q, word_q;
  logic [WORD_W-1:0] left_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              in_frame_q, ext_busy_q;
  logic [IDXW-1:0]   idx;

  // named internal events
  logic              ring_clr, ring_adv, is_ext, cfg_bad, ext_go;
  logic              push_st, push_ok, last_byte;
  logic [PTR_W-1:0]  buf_addr, idx_w;

  assign ring_clr  = (st_q == S_IDLE);
  assign ring_adv  = (st_q == S_WB);
  assign is_ext    = stat_q[ST_EXT];
  assign cfg_bad   = (tfc == FC_BAD);
  assign ext_go    = (st_q == S_DAT_RQ) && is_ext && (!cfg_bad || ext_busy_q);
  assign push_st   = (st_q == S_PUSH_HI) || (st_q == S_PUSH_LO);
  assign push_ok   = push_st && !fifo_full;
  assign last_byte = (left_q == WORD_W'(1));
  assign idx_w     = PTR_W'(idx);

  txbd_ring_ptr #(.NUM_BD(NUM_BD), .IDXW(IDXW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(ring_clr), .adv(ring_adv),
    .wrap(stat_q[ST_WRAP]), .idx(idx)
  );

  txbd_addr_map #(.PTR_W(PTR_W), .INT_W(INT_W)) u_map (
    .ext(is_ext), .ptr(ptr_q), .addr(buf_addr)
  );

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_ext   = 1'b0;
    mem_addr  = desc_addr(BASE_A, idx_w, 2'd0);
    mem_wdata = '0;
    unique case (st_q)
      S_POLL_RQ: mem_req = 1'b1;
      S_LEN_RQ: begin mem_req = 1'b1; mem_addr = desc_addr(BASE_A, idx_w, 2'd1); end
      S_PHI_RQ: begin mem_req = 1'b1; mem_addr = desc_addr(BASE_A, idx_w, 2'd2); end
      S_PLO_RQ: begin mem_req = 1'b1; mem_addr = desc_addr(BASE_A, idx_w, 2'd3); end
      S_DAT_RQ: begin
        mem_addr = buf_addr;
        mem_req  = is_ext ? ext_go : 1'b1;
        mem_ext  = ext_go;
      end
      S_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word(stat_q, 1'b0); end
      S_UR_WR: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word(stat_q, 1'b1); end
      default: ;
    endcase
  end

  assign mem_fc      = mem_ext ? tfc : 3'b000;
  assign fifo_wr     = push_ok;
  assign fifo_data   = (st_q == S_PUSH_HI) ? word_q[15:8] : word_q[7:0];
  assign bd_done     = (st_q == S_WB);
  assign tx_underrun = (st_q == S_UR_WR);
  assign cfg_err     = cfg_bad;
  assign bd_idx      = idx;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (tx_en) st_d = S_POLL_RQ;
      S_POLL_RQ: st_d = S_POLL_WT;
      S_POLL_WT: begin
        if (mem_rdata[ST_READY]) st_d = S_LEN_RQ;
        else if (in_frame_q)     st_d = S_UR_WR;
        else if (!tx_en)         st_d = S_IDLE;
        else                     st_d = S_POLL_RQ;
      end
      S_LEN_RQ:  st_d = S_LEN_WT;
      S_LEN_WT:  st_d = S_PHI_RQ;
      S_PHI_RQ:  st_d = S_PHI_WT;
      S_PHI_WT:  st_d = S_PLO_RQ;
      S_PLO_RQ:  st_d = S_PLO_WT;
      S_PLO_WT:  st_d = (left_q == '0) ? S_WB : S_DAT_RQ;
      S_DAT_RQ: begin
        if (!is_ext)               st_d = S_DAT_WT;
        else if (ext_go && mem_ack) st_d = S_PUSH_HI;
      end
      S_DAT_WT:  st_d = S_PUSH_HI;
      S_PUSH_HI: if (!fifo_full) st_d = last_byte ? S_WB : S_PUSH_LO;
      S_PUSH_LO: if (!fifo_full) st_d = last_byte ? S_WB : S_DAT_RQ;
      S_WB, S_UR_WR: st_d = tx_en ? S_POLL_RQ : S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  // state and datapath registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      stat_q     <= '0;
      word_q     <= '0;
      left_q     <= '0;
      ptr_q      <= '0;
      in_frame_q <= 1'b0;
      ext_busy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      case (st_q)
        S_IDLE:    in_frame_q <= 1'b0;
        S_POLL_WT: stat_q <= mem_rdata;
        S_LEN_WT:  left_q <= mem_rdata;
        S_PHI_WT:  ptr_q[PTR_W-1:16] <= mem_rdata[PTR_W-17:0];
        S_PLO_WT:  ptr_q[15:0] <= mem_rdata;
        S_DAT_RQ: begin
          if (ext_go) begin
            ext_busy_q <= !mem_ack;
            if (mem_ack) word_q <= mem_rdata;
          end
        end
        S_DAT_WT:  word_q <= mem_rdata;
        S_WB:      in_frame_q <= !stat_q[ST_LAST];
        S_UR_WR:   in_frame_q <= 1'b0;
        default: ;
      endcase
      if (push_ok) left_q <= left_q - 1'b1;
      if (push_ok && st_q == S_PUSH_LO) ptr_q <= ptr_q + PTR_W'(2);
    end
  end

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ext && !mem_ack) |=> (mem_req && mem_ext && $stable(mem_addr)));

  // R10
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ext && !$past(mem_req && mem_ext)) |-> !cfg_err);

  // R7
  fifo_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_st && fifo_full) |=> (st_q == $past(st_q) && left_q == $past(left_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_done |=> !bd_done);

  // R8
  wb_ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[ST_READY]);

  // R9
  ur_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> (mem_we && mem_wdata[ST_UNDR] && !mem_ext));

  // R5
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (left_q != '0));
endmodule

// File: tb/txbd_ring_engine_bench.sv
module txbd_ring_engine_bench;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n, tx_en;
  logic [2:0]  tfc_drv;
  logic        mem_req, mem_we, mem_ext, mem_ack;
  logic [2:0]  mem_fc;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        fifo_wr, fifo_full, bd_done, tx_underrun, cfg_err;
  logic [7:0]  fifo_data;
  logic [2:0]  bd_idx;

  always #5 clk = ~clk;

  txbd_ring_engine u_txbd_ring_engine (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tfc(tfc_drv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ext(mem_ext), .mem_fc(mem_fc),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_full(fifo_full), .bd_done(bd_done), .tx_underrun(tx_underrun),
    .cfg_err(cfg_err), .bd_idx(bd_idx)
  );

  int checks = 0, fails = 0, done_cnt = 0, ur_cnt = 0, wr_cnt = 0;
  bit summary_done = 0;
  logic [7:0]  exp_q [$];
  logic [15:0] ram [0:1023];
  logic [15:0] int_rd = '0, ext_rd = '0;
  logic        ack_q = 1'b0, full_mode = 1'b0;
  int          dly = 0;

  assign mem_ack   = ack_q;
  assign mem_rdata = ack_q ? ext_rd : int_rd;

  function automatic logic [15:0] ipat(input int w);
    return 16'((w * 12061) ^ 15510);
  endfunction

  function automatic logic [15:0] epat(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h5AC3;
  endfunction

  function automatic int nxt(input int i, input bit wrap);
    return (wrap || i == NB - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // memory and FIFO responder
  always @(posedge clk) begin
    if (mem_req && !mem_ext) begin
      if (mem_we) ram[mem_addr[10:1]] = mem_wdata;
      else        int_rd <= ram[mem_addr[10:1]];
    end
    if (mem_req && mem_ext && !ack_q) begin
      if (dly == 0) begin
        ack_q  <= 1'b1;
        ext_rd <= epat(mem_addr);
        dly    <= int'($urandom % 4);
      end else dly <= dly - 1;
    end else ack_q <= 1'b0;
    fifo_full <= full_mode && ($urandom % 3 == 0);
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr) begin
        logic [7:0] b;
        wr_cnt++;
        chk(!fifo_full, "R7 write while full", 32'(fifo_full), 0);
        if (exp_q.size() == 0) chk(0, "R3 unexpected byte", 32'(fifo_data), 0);
        else begin
          b = exp_q.pop_front();
          chk(fifo_data == b, "R5 byte stream", 32'(fifo_data), 32'(b));
        end
      end
      if (mem_req && mem_ext)
        chk(mem_fc == tfc_drv, "R6 function code", 32'(mem_fc), 32'(tfc_drv));
      if (bd_done) done_cnt++;
      if (tx_underrun) ur_cnt++;
    end
  end

  task automatic add_exp(input bit ext, input logic [23:0] ptr, input int len);
    for (int i = 0; i < len; i++) begin
      logic [23:0] a;
      logic [15:0] w;
      a = ptr + 24'(i - (i % 2));
      w = ext ? epat(a) : ipat(int'(a[10:1]));
      exp_q.push_back((i % 2 == 0) ? w[15:8] : w[7:0]);
    end
  endtask

  task automatic put_bd(input int idx, input bit ext, input logic [23:0] ptr, input int len,
                        input bit last, input bit wrap, input bit rdy);
    ram[idx*4+1] = 16'(len);
    ram[idx*4+2] = {8'($urandom), ptr[23:16]};  // upper byte is junk (R1)
    ram[idx*4+3] = ptr[15:0];
    ram[idx*4]   = {rdy, 1'b0, wrap, ext, last, 11'b0};
  endtask

  function automatic logic [23:0] rnd_ptr(input bit ext);
    logic [23:0] p;
    if (ext) p = 24'($urandom) & 24'hFFFFFE;
    else p = {13'($urandom), 11'(256 + 2 * int'($urandom % 768))};
    return p;
  endfunction

  task automatic wait_done(input int target, input string rq);
    int n = 0;
    while (done_cnt < target && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt >= target, rq, 32'(done_cnt), 32'(target));
  endtask

  int b_idx = 0;

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tx_en = 1'b0; tfc_drv = 3'b101;
    for (int w = 0; w < 1024; w++) ram[w] = ipat(w);
    for (int w = 0; w < NB * 4; w++) ram[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !fifo_wr && !bd_done && !tx_underrun, "R2 reset idle",
        {mem_req, fifo_wr, bd_done, tx_underrun}, 0);
    chk(bd_idx == 0, "R2 reset index", 32'(bd_idx), 0);
    begin
      int busy = 0;
      repeat (20) @(negedge clk) if (mem_req) busy++;
      chk(busy == 0, "R2 no access while disabled", 32'(busy), 0);
    end
    tx_en = 1'b1;

    // random frames (R1 R4 R5 R6 R7 R8)
    for (int r = 0; r < 14; r++) begin
      int nb, target;
      int used [3];
      full_mode = (r % 3 == 1);
      nb = 1 + int'($urandom % 3);
      target = done_cnt + nb;
      for (int j = 0; j < nb; j++) begin
        bit ext, wrap;
        int len;
        logic [23:0] p;
        ext  = 1'($urandom);
        wrap = ($urandom % 5 == 0);
        len  = int'($urandom % 10);
        p    = rnd_ptr(ext);
        used[j] = b_idx;
        add_exp(ext, p, len);
        put_bd(b_idx, ext, p, len, j == nb - 1, wrap, 1'b1);
        b_idx = nxt(b_idx, wrap);
      end
      wait_done(target, "R8 buffers completed");
      repeat (4) @(negedge clk);
      for (int j = 0; j < nb; j++)
        chk(ram[used[j]*4][15] == 1'b0 && ram[used[j]*4][1] == 1'b0, "R8 status handed back",
            32'(ram[used[j]*4]), 0);
      chk(bd_idx == 3'(b_idx), "R4 ring position", 32'(bd_idx), 32'(b_idx));
    end
    full_mode = 1'b0;

    // no look-ahead (R3)
    begin
      int ni, w0, d0;
      logic [23:0] p0, p1;
      ni = nxt(b_idx, 0);
      p0 = rnd_ptr(0); p1 = rnd_ptr(1);
      put_bd(ni, 1, p1, 5, 1, 0, 1);
      w0 = wr_cnt; d0 = done_cnt;
      repeat (80) @(negedge clk);
      chk(wr_cnt == w0 && done_cnt == d0, "R3 later entry not skipped to",
          32'(wr_cnt - w0), 0);
      add_exp(0, p0, 6);
      add_exp(1, p1, 5);
      put_bd(b_idx, 0, p0, 6, 1, 0, 1);
      wait_done(d0 + 2, "R3 entries served in order");
      b_idx = nxt(ni, 0);
    end

    // underrun (R9)
    begin
      int ni, d0, u0;
      logic [23:0] p0;
      ni = nxt(b_idx, 0);
      ram[ni*4] = '0;
      p0 = rnd_ptr(0);
      u0 = ur_cnt; d0 = done_cnt;
      add_exp(0, p0, 3);
      put_bd(b_idx, 0, p0, 3, 0, 0, 1);
      wait_done(d0 + 1, "R9 first buffer of frame");
      repeat (30) @(negedge clk);
      chk(ur_cnt == u0 + 1, "R9 single underrun pulse", 32'(ur_cnt - u0), 1);
      chk(ram[ni*4][1] == 1'b1 && ram[ni*4][15] == 1'b0, "R9 underrun flag in entry",
          32'(ram[ni*4]), 16'h0002);
      chk(bd_idx == 3'(ni), "R9 still on stalled entry", 32'(bd_idx), 32'(ni));
      p0 = rnd_ptr(1);
      add_exp(1, p0, 4);
      put_bd(ni, 1, p0, 4, 1, 0, 1);
      wait_done(d0 + 2, "R9 entry served after refill");
      repeat (4) @(negedge clk);
      chk(ram[ni*4][1] == 1'b0, "R8 underrun bit cleared on hand-back", 32'(ram[ni*4]), 0);
      chk(ur_cnt == u0 + 1, "R9 no further underrun", 32'(ur_cnt - u0), 1);
      b_idx = nxt(ni, 0);
    end

    // illegal function code (R10)
    begin
      int w0, d0;
      logic [23:0] p0;
      tfc_drv = 3'b111;
      @(negedge clk);
      chk(cfg_err == 1'b1, "R10 cfg_err raised", 32'(cfg_err), 1);
      p0 = rnd_ptr(1);
      w0 = wr_cnt; d0 = done_cnt;
      add_exp(1, p0, 5);
      put_bd(b_idx, 1, p0, 5, 1, 0, 1);
      repeat (60) @(negedge clk);
      chk(wr_cnt == w0 && done_cnt == d0, "R10 external read held off", 32'(wr_cnt - w0), 0);
      tfc_drv = 3'b010;
      @(negedge clk);
      chk(cfg_err == 1'b0, "R10 cfg_err cleared", 32'(cfg_err), 0);
      wait_done(d0 + 1, "R10 resumes after fix");
      b_idx = nxt(b_idx, 0);
    end

    // empty and single-byte buffers (R5)
    begin
      int d0;
      logic [23:0] p0, p1;
      d0 = done_cnt;
      p0 = rnd_ptr(0); p1 = rnd_ptr(1);
      put_bd(b_idx, 0, p0, 0, 1, 0, 1);
      add_exp(1, p1, 1);
      put_bd(nxt(b_idx, 0), 1, p1, 1, 1, 1, 1);
      wait_done(d0 + 2, "R5 zero and one byte buffers");
      b_idx = 0;
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all bytes delivered", 32'(exp_q.size()), 0);
      chk(bd_idx == 0, "R4 wrap bit returns to entry 0", 32'(bd_idx), 0);
    end

    // disable returns to entry 0 (R2)
    tx_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(!mem_req && bd_idx == 0, "R2 idle after disable", {mem_req, 3'(bd_idx)}, 0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    finish_run();
  end
endmodule